// File: doc/BRIEF.md
# Register-mapped watchdog timer

A countdown watchdog that a host controls over a plain 32-bit register bus with one-cycle write and read strobes. Three word registers sit at strided offsets from a base address: the timeout count, the status flag and the pet register. The host programs the timeout and then keeps writing the pet register before the count runs out. If it stops, the watchdog "bites". It raises a sticky flag, shows it in status bit 0 and drives a bite output that downstream logic uses, for example to disable machine outputs.

Recovery works like this. The host writes the timeout register, then writes the status register with bit 0 clear. That drops the flag and restarts the countdown. While the flag is set the counter is frozen and pets do nothing. Only the deliberate clear brings the block out of the bitten state.

Top module: `wdt_core`

## Requirements
- R1: After reset, bite_o is 0, status reads 0 and the timeout register reads DEFAULT_TIMEOUT. The countdown starts from DEFAULT_TIMEOUT, so bite_o rises DEFAULT_TIMEOUT+1 cycles after reset is released.
- R2: A write to the timeout register (offset BASE+0*STRIDE) reloads the countdown with the new value N. bite_o rises exactly N+1 clock cycles after the reloading write edge, unless another reload occurs first.
- R3: Once set, the bite flag stays set. bite_o stays 1 and status bit 0 reads 1 until a clearing status write. While set, the counter is frozen and key pets do not clear it.
- R4: A status write (offset BASE+1*STRIDE) with data bit 0 = 0 clears the flag and reloads the countdown from the stored timeout. A status write with bit 0 = 1 has no effect.
- R5: A write to the pet register (offset BASE+2*STRIDE) whose data bits [31:24] equal 0x5A reloads the countdown from the stored timeout. A pet write with any other top byte is ignored.
- R6: The stored timeout is 31 bits wide. Write data bit 31 is dropped, so writing 0xFFFFFFFF stores 0x7FFFFFFF. Reads return the stored count with bit 31 = 0.
- R7: A read strobe returns data on rd_data_o with rd_valid_o high in the following cycle. Status reads as {31'b0, flag}, the pet register and unmapped addresses read as 0.
- R8: Only addresses exactly equal to BASE+k*STRIDE (k = 0,1,2) are decoded. Writes to any other address, including unaligned ones, have no effect.
- R9: A reload (key pet, timeout write or clear) in the same cycle as the count reaching expiry wins: no bite occurs and the new count starts.
- R10: A timeout of 0 bites one cycle after the reloading write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Write strobe, one cycle per write |
| rd_en_i | input | 1 | Read strobe, one cycle per read |
| addr_i | input | ADDR_W | Byte address of the access |
| wdata_i | input | 32 | Write data |
| rd_data_o | output | 32 | Read data, valid the cycle after rd_en_i |
| rd_valid_o | output | 1 | High when rd_data_o carries a read result |
| bite_o | output | 1 | Sticky bite flag, high once the timeout expires |

## Verification
The bench times every expiry to the exact cycle after each kind of reload. A design that counted N cycles instead of N+1, or that ignored the reload on a timeout write, would bite one cycle early or at the wrong moment.

Further checks cover the following corner cases:
- A pet with a wrong key must not rescue the timer. A design that reloaded on any pet would then stay quiet.
- A pet that arrives on the very cycle of expiry must win. A design that gave expiry priority would bite there.
- Pets, status writes with bit 0 set and unaligned writes are all sent while bitten. A design that leaked any of them would drop the flag early.
- Writing 0xFFFFFFFF and then 0x80000003 probes the 31-bit field. A design that kept bit 31 would read it back.
- A zero timeout probes the immediate bite, which a design with an off-by-one counter would miss.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int DATA_W   = 32;
  localparam int NUM_REGS = 3;

  typedef enum logic [1:0] {
    SEL_NONE    = 2'd0,
    SEL_TIMEOUT = 2'd1,
    SEL_STATUS  = 2'd2,
    SEL_PET     = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/wdt_addr_decode.sv
module wdt_addr_decode
  import wdt_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int BASE   = 0,
  parameter int STRIDE = 4
) (
  input  logic [ADDR_W-1:0] addr_i,
  output reg_sel_e          sel_o
);
  logic [NUM_REGS-1:0] hit;

  for (genvar k = 0; k < NUM_REGS; k++) begin : g_hit
    assign hit[k] = (addr_i == ADDR_W'(BASE + k * STRIDE));
  end

  always_comb begin
    if (hit[0])      sel_o = SEL_TIMEOUT;
    else if (hit[1]) sel_o = SEL_STATUS;
    else if (hit[2]) sel_o = SEL_PET;
    else             sel_o = SEL_NONE;
  end
endmodule

// File: rtl/wdt_countdown.sv
module wdt_countdown #(
  parameter int          CNT_W   = 31,
  parameter int unsigned DEFAULT = 1000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             expire_o
);
  logic [CNT_W-1:0] cnt_q;

  // load beats expiry in the same cycle
  assign expire_o = run_i && !load_i && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      cnt_q <= CNT_W'(DEFAULT);
    else if (load_i)                  cnt_q <= load_val_i;
    else if (run_i && cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end
endmodule

// File: rtl/wdt_bite_flag.sv
module wdt_bite_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     flag_o <= 1'b0;
    else if (clr_i)  flag_o <= 1'b0;
    else if (set_i)  flag_o <= 1'b1;
  end
endmodule

// File: rtl/wdt_core.sv
module wdt_core
  import wdt_pkg::*;
#(
  parameter int          ADDR_W          = 8,
  parameter int          BASE            = 0,
  parameter int          STRIDE          = 4,
  parameter int          CNT_W           = 31,
  parameter int unsigned DEFAULT_TIMEOUT = 1000,
  parameter logic [7:0]  PET_KEY         = 8'h5A
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rd_data_o,
  output logic              rd_valid_o,
  output logic              bite_o
);
  localparam int PAD_W = DATA_W - CNT_W;

  reg_sel_e         sel;
  logic [CNT_W-1:0] timeout_q;
  logic             flag;
  logic             expire;
  logic             wr_timeout, wr_clear, wr_pet_ok;
  logic             load;
  logic [CNT_W-1:0] load_val;
  logic [31:0]      rd_mux;

  wdt_addr_decode #(
    .ADDR_W(ADDR_W), .BASE(BASE), .STRIDE(STRIDE)
  ) u_decode (
    .addr_i(addr_i),
    .sel_o (sel)
  );

  assign wr_timeout = wr_en_i && (sel == SEL_TIMEOUT);
  assign wr_clear   = wr_en_i && (sel == SEL_STATUS) && !wdata_i[0];
  assign wr_pet_ok  = wr_en_i && (sel == SEL_PET) && (wdata_i[31:24] == PET_KEY) && !flag;

  assign load     = wr_timeout || wr_clear || wr_pet_ok;
  assign load_val = wr_timeout ? wdata_i[CNT_W-1:0] : timeout_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         timeout_q <= CNT_W'(DEFAULT_TIMEOUT);
    else if (wr_timeout) timeout_q <= wdata_i[CNT_W-1:0];
  end

  wdt_countdown #(
    .CNT_W(CNT_W), .DEFAULT(DEFAULT_TIMEOUT)
  ) u_count (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (!flag),
    .load_i    (load),
    .load_val_i(load_val),
    .expire_o  (expire)
  );

  wdt_bite_flag u_flag (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (expire),
    .clr_i (wr_clear),
    .flag_o(flag)
  );

  assign bite_o = flag;

  always_comb begin
    unique case (sel)
      SEL_TIMEOUT: rd_mux = {{PAD_W{1'b0}}, timeout_q};
      SEL_STATUS:  rd_mux = {31'b0, flag};
      default:     rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_valid_o <= 1'b0;
      rd_data_o  <= '0;
    end else begin
      rd_valid_o <= rd_en_i;
      if (rd_en_i) rd_data_o <= rd_mux;
    end
  end
endmodule

// File: rtl/wdt_checker.sv
module wdt_checker #(
  parameter int         ADDR_W  = 8,
  parameter int         BASE    = 0,
  parameter int         STRIDE  = 4,
  parameter logic [7:0] PET_KEY = 8'h5A
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic              rd_en_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [31:0]       wdata_i,
  input logic [31:0]       rd_data_o,
  input logic              rd_valid_o,
  input logic              bite_o
);
  logic at_to, at_st, at_pet, clear_wr, reload_wr;
  assign at_to     = (addr_i == ADDR_W'(BASE));
  assign at_st     = (addr_i == ADDR_W'(BASE + STRIDE));
  assign at_pet    = (addr_i == ADDR_W'(BASE + 2 * STRIDE));
  assign clear_wr  = wr_en_i && at_st && !wdata_i[0];
  assign reload_wr = wr_en_i && (at_to || clear_wr || (at_pet && wdata_i[31:24] == PET_KEY));

  assert_bite_sticky_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bite_o && !clear_wr |=> bite_o);

  assert_clear_drops_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_wr |=> !bite_o);

  assert_no_bite_on_reload_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(bite_o) |-> !$past(reload_wr));

  assert_rd_valid_follows_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i |=> rd_valid_o);

  assert_rd_valid_idle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> !rd_valid_o);

  assert_pet_reads_zero_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i && at_pet |=> rd_data_o == 32'd0);

  assert_status_read_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i && at_st |=> rd_data_o == {31'b0, $past(bite_o)});

  assert_timeout_msb_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i && at_to |=> !rd_data_o[31]);
endmodule

bind wdt_core wdt_checker #(
  .ADDR_W(ADDR_W), .BASE(BASE), .STRIDE(STRIDE), .PET_KEY(PET_KEY)
) u_chk (.*);

// File: tb/wdt_core_tb.sv
module wdt_core_tb;
  localparam int ADDR_W = 8;
  localparam int BASE   = 'h20;
  localparam int STRIDE = 4;
  localparam int DEF_TO = 20;
  localparam logic [ADDR_W-1:0] A_TO  = ADDR_W'(BASE);
  localparam logic [ADDR_W-1:0] A_ST  = ADDR_W'(BASE + STRIDE);
  localparam logic [ADDR_W-1:0] A_PET = ADDR_W'(BASE + 2 * STRIDE);
  localparam logic [ADDR_W-1:0] A_BAD = ADDR_W'(BASE + 3 * STRIDE);

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic              wr_en = 1'b0, rd_en = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [31:0]       wdata = '0;
  logic [31:0]       rd_data;
  logic              rd_valid, bite;

  int n_tests = 0, n_fail = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #2 clk = ~clk;

  wdt_core #(
    .ADDR_W(ADDR_W), .BASE(BASE), .STRIDE(STRIDE), .DEFAULT_TIMEOUT(DEF_TO)
  ) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .addr_i(addr), .wdata_i(wdata), .rd_data_o(rd_data),
    .rd_valid_o(rd_valid), .bite_o(bite)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic check_bite(input string tag, input logic exp);
    check(bite === exp, tag, {31'b0, bite}, {31'b0, exp});
  endtask

  // called at a negedge; access lands on the next posedge
  task automatic bus_write(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; wdata = '0;
  endtask

  task automatic bus_read(input logic [ADDR_W-1:0] a, input logic [31:0] exp, input string tag);
    exp_q.push_back(exp); tag_q.push_back(tag);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic arm(input logic [31:0] t);
    bus_write(A_TO, t);
    bus_write(A_ST, 32'h0);
  endtask

  // monitor: compares read results against the scoreboard queue
  always @(negedge clk) begin
    if (rst_ni && rd_valid) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R7 unexpected read data", rd_data, 32'h0);
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(rd_data === e, t, rd_data, e);
      end
    end
  end

  initial begin
    #(200000 * 4);
    n_tests++; n_fail++;
    $display("FAIL watchdog: run hung, actual 0x%08h expected 0x%08h", 32'h0, 32'h1);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    wait_cyc(3);
    rst_ni = 1'b1;
    check_bite("R1 bite low out of reset", 1'b0);
    bus_read(A_ST, 32'h0, "R1 status after reset");
    bus_read(A_TO, DEF_TO, "R1 timeout after reset");
    wait_cyc(DEF_TO - 2);
    check_bite("R1 no bite at DEFAULT cycles", 1'b0);
    wait_cyc(1);
    check_bite("R1 bite at DEFAULT+1 cycles", 1'b1);

    // bitten: status, frozen, pets and set-writes ignored
    bus_read(A_ST, 32'h1, "R3 status shows bite");
    bus_write(A_PET, 32'h5A00_0000);
    wait_cyc(3);
    check_bite("R3 key pet while bitten ignored", 1'b1);
    bus_write(A_ST, 32'h1);
    check_bite("R4 status write bit0=1 no clear", 1'b1);
    bus_write(ADDR_W'(BASE + 1), 32'h0);
    check_bite("R8 unaligned write ignored", 1'b1);
    bus_write(A_BAD, 32'h0);
    check_bite("R8 unmapped write ignored", 1'b1);
    bus_read(A_ST, 32'h1, "R3 status still set");

    // timeout written while bitten, then clear reloads from it
    bus_write(A_TO, 32'd10);
    check_bite("R3 timeout write keeps flag", 1'b1);
    bus_write(A_ST, 32'h0);
    check_bite("R4 clear drops bite", 1'b0);
    wait_cyc(10);
    check_bite("R4 no bite at T after clear", 1'b0);
    wait_cyc(1);
    check_bite("R4 bite at T+1 after clear", 1'b1);

    // timeout write reload timing
    bus_write(A_ST, 32'h0);
    bus_write(A_TO, 32'd7);
    wait_cyc(7);
    check_bite("R2 no bite at N after write", 1'b0);
    wait_cyc(1);
    check_bite("R2 bite at N+1 after write", 1'b1);

    // good pet
    arm(32'd30);
    wait_cyc(20);
    bus_write(A_PET, 32'h5A12_3456);
    wait_cyc(30);
    check_bite("R5 key pet reloads", 1'b0);
    wait_cyc(1);
    check_bite("R5 bite T+1 after pet", 1'b1);

    // bad pet
    arm(32'd30);
    bus_read(A_PET, 32'h0, "R7 pet register reads zero");
    bus_read(A_BAD, 32'h0, "R7 unmapped reads zero");
    wait_cyc(8);
    bus_write(A_PET, 32'h5B00_0000);
    wait_cyc(19);
    check_bite("R5 bad key before expiry", 1'b0);
    wait_cyc(1);
    check_bite("R5 bad key pet ignored", 1'b1);

    // pet on expiry cycle wins
    arm(32'd5);
    wait_cyc(5);
    bus_write(A_PET, 32'h5A00_0000);
    check_bite("R9 pet on expiry cycle wins", 1'b0);
    wait_cyc(5);
    check_bite("R9 no bite before reload end", 1'b0);
    wait_cyc(1);
    check_bite("R9 bite after reloaded count", 1'b1);

    // zero timeout
    arm(32'd0);
    check_bite("R10 zero timeout no bite at write", 1'b0);
    wait_cyc(1);
    check_bite("R10 zero timeout bites next cycle", 1'b1);

    // field width and unmapped write
    bus_write(A_TO, 32'hFFFF_FFFF);
    bus_read(A_TO, 32'h7FFF_FFFF, "R6 bit31 dropped on max write");
    bus_write(A_TO, 32'h8000_0003);
    bus_read(A_TO, 32'h0000_0003, "R6 bit31 dropped");
    bus_write(A_BAD, 32'h0000_0055);
    bus_read(A_TO, 32'h0000_0003, "R8 unmapped write leaves timeout");

    wait_cyc(2);
    check(exp_q.size() == 0, "R7 all reads answered", exp_q.size(), 32'h0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule